// File: doc/BRIEF.md
# Boot Target Selector with Address-Zero Remap

This block decides which memory answers at the bottom of the address space once the chip comes out of reset. Three strap-like option inputs, a boot pin and a flag from the flash controller saying that the first flash word is erased together pick one of five targets: main flash, system memory, SRAM1, external parallel memory bank 1 or serial flash. The block captures that choice on the first clock after reset is released, and it captures it again when a wake-from-standby pulse arrives. The straps can change at any other time without effect.

The captured choice loads a remap register that software can later overwrite with a three-bit target code. The current target is shown as a one-hot vector. The block also translates bus addresses. An address inside the 128 MB alias window at zero is turned into the target's native address, or it is flagged as a decode error when it lies past the end of that target. Any other address passes through untouched, so an aliased memory can still be reached at its own address.

Top module: `boot_remap_top`

## Requirements
- R1: With `opt_pin_src`=1 the effective boot bit equals `boot_pin`. With `opt_pin_src`=0 it equals the inverse of `opt_boot_n`.
- R2: When the effective boot bit is 0, main flash is selected (`sel_onehot`=5'b00001), except in the case covered by R3.
- R3: When `opt_pin_src`=1, `boot_pin`=0 and `flash_blank`=1, system memory is selected (5'b00010). When `opt_pin_src`=0, `flash_blank` has no effect.
- R4: When the effective boot bit is 1, SRAM1 is selected (5'b00100) if `opt_alt_n`=0, and system memory is selected if `opt_alt_n`=1.
- R5: The boot choice is captured on the first rising clock edge after `rst_n` goes high. Later changes to the boot inputs leave `sel_onehot` unchanged.
- R6: A `wake` pulse captures the boot inputs again and reloads the remap register. If `wake` and `remap_we` are high in the same cycle, `wake` wins.
- R7: `remap_we` with `remap_code` 0 (flash), 1 (system memory), 2 (SRAM1), 3 (external parallel) or 4 (serial flash) selects that target from the next cycle. Target k drives bit k of `sel_onehot`, and exactly one bit is ever set.
- R8: Writes with `remap_code` 5, 6 or 7 are ignored.
- R9: When `acc_valid`=1 and `acc_addr` is below 0x0800_0000, one cycle later `xl_valid`=1, `xl_alias`=1 and `xl_addr` = target base + `acc_addr`. The bases are: flash 0x0800_0000, system memory 0x1FFF_0000, SRAM1 0x2000_0000, external parallel 0x6000_0000, serial 0x9000_0000. An access in the same cycle as a remap write uses the old target.
- R10: An aliased access at or beyond the target size raises `xl_err`=1 with `xl_addr`=0. The sizes are: flash 0x10_0000, system memory 0x7000, SRAM1 0x2_0000, and 0x1000_0000 for each external memory.
- R11: An access at or above 0x0800_0000 returns `xl_addr`=`acc_addr` with `xl_alias`=0 and `xl_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin | input | 1 | External boot pin level |
| opt_pin_src | input | 1 | Option: 1 takes the boot bit from the pin, 0 from `opt_boot_n` |
| opt_boot_n | input | 1 | Option: inverted boot bit, used when `opt_pin_src`=0 |
| opt_alt_n | input | 1 | Option: picks system memory (1) or SRAM1 (0) when the boot bit is 1 |
| flash_blank | input | 1 | First flash word reads all ones |
| wake | input | 1 | Pulse on leaving standby; captures the boot inputs again |
| remap_we | input | 1 | Remap register write strobe |
| remap_code | input | 3 | Target code to write |
| acc_valid | input | 1 | Address translation request |
| acc_addr | input | 32 | Address to translate |
| sel_onehot | output | 5 | Current address-zero target, one-hot |
| xl_valid | output | 1 | Translation result valid |
| xl_addr | output | 32 | Translated address |
| xl_alias | output | 1 | The request fell in the alias window |
| xl_err | output | 1 | Decode error: offset beyond target size |

## Verification
The bench first covers the erased-flash fallback. A design that ignored the source of the boot bit would divert an option-sourced boot into system memory. It then changes the straps after reset release and checks that the selection stays put, which catches a design that decodes the straps combinationally. It also checks that a wake pulse beats a write in the same cycle, and that an access issued together with a write still uses the old target. The window checks probe the last legal word and the first illegal word of a small target. They also send an address just above the alias window, which a wrong comparison would alias or flag as an error.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
  localparam int NTGT   = 5;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    TGT_FLASH  = 3'd0,
    TGT_SYSMEM = 3'd1,
    TGT_SRAM1  = 3'd2,
    TGT_EXTPAR = 3'd3,
    TGT_SERIAL = 3'd4
  } tgt_e;

  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NTGT - 1);
endpackage

// File: rtl/boot_decide.sv
module boot_decide
  import boot_remap_pkg::*;
(
  input  logic boot_pin,
  input  logic opt_pin_src,
  input  logic opt_boot_n,
  input  logic opt_alt_n,
  input  logic flash_blank,
  output tgt_e boot_tgt
);
  logic eff_boot;

  always_comb begin
    eff_boot = opt_pin_src ? boot_pin : ~opt_boot_n;
    if (eff_boot) begin
      boot_tgt = opt_alt_n ? TGT_SYSMEM : TGT_SRAM1;
    end else if (opt_pin_src && flash_blank) begin
      boot_tgt = TGT_SYSMEM;
    end else begin
      boot_tgt = TGT_FLASH;
    end
  end
endmodule

// File: rtl/remap_ctl.sv
module remap_ctl
  import boot_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              boot_tgt,
  input  logic              wake,
  input  logic              remap_we,
  input  logic [CODE_W-1:0] remap_code,
  output tgt_e              cur_tgt,
  output logic [NTGT-1:0]   sel_onehot
);
  logic pend_q, pend_d;
  tgt_e cur_q, cur_d;
  logic capture;

  always_comb begin
    capture = pend_q | wake;
    pend_d  = 1'b0;
    cur_d   = cur_q;
    if (capture) begin
      cur_d = boot_tgt;
    end else if (remap_we && (remap_code <= LAST_CODE)) begin
      cur_d = tgt_e'(remap_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      cur_q  <= TGT_FLASH;
    end else begin
      pend_q <= pend_d;
      cur_q  <= cur_d;
    end
  end

  assign cur_tgt = cur_q;

  for (genvar i = 0; i < NTGT; i++) begin : g_sel
    assign sel_onehot[i] = (cur_q == CODE_W'(i));
  end

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_onehot) == 1);

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !wake && !remap_we) |=> $stable(sel_onehot));

  // R8
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !wake && remap_we && remap_code > LAST_CODE) |=> $stable(sel_onehot));

  // R6
  wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (cur_q == $past(boot_tgt)));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import boot_remap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ALIAS_AW = 27,
  parameter logic [NTGT-1:0][ADDR_W-1:0] TGT_BASE = '0,
  parameter logic [NTGT-1:0][ADDR_W-1:0] TGT_SIZE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              cur_tgt,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              xl_valid,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              xl_alias,
  output logic              xl_err
);
  localparam int HI_W = ADDR_W - ALIAS_AW;

  logic              v_q;
  logic [ADDR_W-1:0] a_q, a_d;
  logic              al_q, al_d, e_q, e_d;
  logic              in_win, in_size;

  always_comb begin
    in_win  = (acc_addr[ADDR_W-1:ALIAS_AW] == HI_W'(0));
    in_size = (acc_addr < TGT_SIZE[cur_tgt]);
    al_d    = in_win;
    e_d     = in_win && !in_size;
    if (!in_win)      a_d = acc_addr;
    else if (in_size) a_d = TGT_BASE[cur_tgt] + acc_addr;
    else              a_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      a_q  <= '0;
      al_q <= 1'b0;
      e_q  <= 1'b0;
    end else begin
      v_q <= acc_valid;
      if (acc_valid) begin
        a_q  <= a_d;
        al_q <= al_d;
        e_q  <= e_d;
      end
    end
  end

  assign xl_valid = v_q;
  assign xl_addr  = a_q;
  assign xl_alias = al_q;
  assign xl_err   = e_q;

  // R9
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> xl_valid);

  // R10
  err_in_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_err |-> (xl_alias && xl_addr == '0));

  // R11
  pass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[ADDR_W-1:ALIAS_AW] != HI_W'(0)) |=> (!xl_alias && xl_addr == $past(acc_addr)));
endmodule

// File: rtl/boot_remap_top.sv
module boot_remap_top
  import boot_remap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ALIAS_AW = 27,
  parameter logic [NTGT-1:0][ADDR_W-1:0] TGT_BASE = {
    32'h9000_0000, 32'h6000_0000, 32'h2000_0000, 32'h1FFF_0000, 32'h0800_0000},
  parameter logic [NTGT-1:0][ADDR_W-1:0] TGT_SIZE = {
    32'h1000_0000, 32'h1000_0000, 32'h0002_0000, 32'h0000_7000, 32'h0010_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_pin,
  input  logic              opt_pin_src,
  input  logic              opt_boot_n,
  input  logic              opt_alt_n,
  input  logic              flash_blank,
  input  logic              wake,
  input  logic              remap_we,
  input  logic [2:0]        remap_code,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [4:0]        sel_onehot,
  output logic              xl_valid,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              xl_alias,
  output logic              xl_err
);
  tgt_e boot_tgt;
  tgt_e cur_tgt;

  boot_decide u_decide (
    .boot_pin    (boot_pin),
    .opt_pin_src (opt_pin_src),
    .opt_boot_n  (opt_boot_n),
    .opt_alt_n   (opt_alt_n),
    .flash_blank (flash_blank),
    .boot_tgt    (boot_tgt)
  );

  remap_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_tgt   (boot_tgt),
    .wake       (wake),
    .remap_we   (remap_we),
    .remap_code (remap_code),
    .cur_tgt    (cur_tgt),
    .sel_onehot (sel_onehot)
  );

  addr_xlate #(
    .ADDR_W   (ADDR_W),
    .ALIAS_AW (ALIAS_AW),
    .TGT_BASE (TGT_BASE),
    .TGT_SIZE (TGT_SIZE)
  ) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_tgt   (cur_tgt),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .xl_valid  (xl_valid),
    .xl_addr   (xl_addr),
    .xl_alias  (xl_alias),
    .xl_err    (xl_err)
  );
endmodule

// File: tb/boot_remap_top_test.sv
`timescale 1ns/1ps
module boot_remap_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b0, opt_pin_src = 1'b1, opt_boot_n = 1'b1;
  logic        opt_alt_n = 1'b0, flash_blank = 1'b0, wake = 1'b0;
  logic        remap_we = 1'b0;
  logic [2:0]  remap_code = 3'd0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = 32'd0;
  logic [4:0]  sel_onehot;
  logic        xl_valid, xl_alias, xl_err;
  logic [31:0] xl_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_remap_top uut (
    .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .opt_pin_src(opt_pin_src),
    .opt_boot_n(opt_boot_n), .opt_alt_n(opt_alt_n), .flash_blank(flash_blank),
    .wake(wake), .remap_we(remap_we), .remap_code(remap_code),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .sel_onehot(sel_onehot),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_alias(xl_alias), .xl_err(xl_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic boot_with(input logic src, input logic pin, input logic b0n,
                           input logic alt, input logic blank);
    @(negedge clk);
    rst_n = 1'b0;
    opt_pin_src = src; boot_pin = pin; opt_boot_n = b0n;
    opt_alt_n = alt; flash_blank = blank;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic access(input logic [31:0] a);
    acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic write_code(input logic [2:0] c);
    remap_we = 1'b1; remap_code = c;
    @(negedge clk);
    remap_we = 1'b0;
  endtask

  task automatic t_boot_decode;
    boot_with(1, 0, 1, 0, 0); check("R2 pin 0 flash", 32'(sel_onehot), 32'h01);
    boot_with(1, 0, 1, 0, 1); check("R3 blank flash to sysmem", 32'(sel_onehot), 32'h02);
    boot_with(0, 1, 1, 0, 1); check("R3 option source ignores blank", 32'(sel_onehot), 32'h01);
    boot_with(0, 0, 0, 0, 0); check("R1 option boot_n 0 gives sram1", 32'(sel_onehot), 32'h04);
    boot_with(1, 1, 0, 1, 0); check("R1 pin wins over option", 32'(sel_onehot), 32'h02);
    boot_with(1, 1, 1, 0, 0); check("R4 alt_n 0 sram1", 32'(sel_onehot), 32'h04);
    boot_with(1, 1, 1, 1, 0); check("R4 alt_n 1 sysmem", 32'(sel_onehot), 32'h02);
  endtask

  task automatic t_latch_wake;
    boot_with(1, 0, 1, 0, 0);
    boot_pin = 1'b1; opt_alt_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 straps ignored after capture", 32'(sel_onehot), 32'h01);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    check("R6 wake resample", 32'(sel_onehot), 32'h04);
    boot_pin = 1'b0;
    wake = 1'b1; remap_we = 1'b1; remap_code = 3'd4;
    @(negedge clk);
    wake = 1'b0; remap_we = 1'b0;
    check("R6 wake beats write", 32'(sel_onehot), 32'h01);
  endtask

  task automatic t_remap;
    boot_with(1, 0, 1, 0, 0);
    write_code(3'd3); check("R7 code 3 extpar", 32'(sel_onehot), 32'h08);
    write_code(3'd4); check("R7 code 4 serial", 32'(sel_onehot), 32'h10);
    write_code(3'd6); check("R8 code 6 ignored", 32'(sel_onehot), 32'h10);
    write_code(3'd7); check("R8 code 7 ignored", 32'(sel_onehot), 32'h10);
    write_code(3'd5); check("R8 code 5 ignored", 32'(sel_onehot), 32'h10);
    write_code(3'd1); check("R7 code 1 sysmem", 32'(sel_onehot), 32'h02);
  endtask

  task automatic t_xlate;
    boot_with(1, 0, 1, 0, 0);
    access(32'h0000_0100);
    check("R9 flash valid", 32'(xl_valid), 32'd1);
    check("R9 flash addr", xl_addr, 32'h0800_0100);
    check("R9 flash alias", 32'(xl_alias), 32'd1);
    access(32'h0010_0000);
    check("R10 flash overrun err", 32'(xl_err), 32'd1);
    check("R10 flash overrun addr", xl_addr, 32'h0);
    write_code(3'd1);
    access(32'h0000_6FFC);
    check("R9 sysmem last word", xl_addr, 32'h1FFF_6FFC);
    check("R10 sysmem last word no err", 32'(xl_err), 32'd0);
    access(32'h0000_7000);
    check("R10 sysmem first bad", 32'(xl_err), 32'd1);
    write_code(3'd3);
    access(32'h07FF_FFFC);
    check("R9 extpar top of window", xl_addr, 32'h67FF_FFFC);
    access(32'h0800_0000);
    check("R11 above window addr", xl_addr, 32'h0800_0000);
    check("R11 above window alias", 32'(xl_alias), 32'd0);
    check("R11 above window err", 32'(xl_err), 32'd0);
    remap_we = 1'b1; remap_code = 3'd2;
    acc_valid = 1'b1; acc_addr = 32'h0000_0040;
    @(negedge clk);
    remap_we = 1'b0; acc_valid = 1'b0;
    check("R9 same-cycle write uses old target", xl_addr, 32'h6000_0040);
    access(32'h0001_0000);
    check("R9 sram1 after write", xl_addr, 32'h2001_0000);
    access(32'h0002_0000);
    check("R10 sram1 overrun", 32'(xl_err), 32'd1);
  endtask

  initial begin
    @(negedge clk);
    check("R7 reset sel", 32'(sel_onehot), 32'h01);
    check("R9 reset xl_valid", 32'(xl_valid), 32'd0);
    t_boot_decode();
    t_latch_wake();
    t_remap();
    t_xlate();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule